// File: doc/BRIEF.md
# Breakpoint Return Address Selector

This block decides which program counter value a debug unit stores when an instruction-fetch breakpoint fires, and when the break is actually taken. One input selects between two timings. In the first, the break lands before the matched instruction runs, and the instruction is suppressed. In the second, the instruction runs first and the break lands afterwards.

Delayed branches need special handling. The instruction in a delay slot cannot be restarted on its own. So a break before a slot instruction resumes at the branch that owns the slot. A break after a delayed branch, or after its slot, resumes at the branch destination. In that case the break waits until fetch reaches the first instruction at the target.

The debug logic pulses a match strobe and supplies the matched instruction's context. The block registers the chosen address and a suppress flag, holds them until the next match, and emits a one-cycle take strobe when the break should enter exception handling.

Top module: `brk_ret_sel`

## Requirements
- R1: While the synchronous active-high reset is high, and on the cycle after it, `save_addr` is 0, `suppress` is 0 and `take` is 0. Reset also clears any break that is still waiting.
- R2: A match with `mode_after`=0 on an instruction with `is_slot`=0 sets `save_addr` to `insn_addr` and `suppress` to 1 after the next clock edge. `take` pulses in that same cycle, whether or not `is_dbr` is set.
- R3: A match with `mode_after`=0 and `is_slot`=1 sets `save_addr` to `owner_addr`, the address of the delayed branch that owns the slot.
- R4: A match with `mode_after`=1 on an instruction with `is_dbr`=0 and `is_slot`=0 sets `save_addr` to `next_addr` and `suppress` to 0. `take` pulses one cycle after the first `boundary` strobe that follows the match cycle.
- R5: A match with `mode_after`=1 and `is_dbr`=1 or `is_slot`=1 sets `save_addr` to `tgt_addr`. `take` pulses only one cycle after the first `tgt_fetch` strobe that follows the match cycle; `boundary` strobes have no effect while it waits.
- R6: Bit 0 of `save_addr` is always 0, whatever the selected source address.
- R7: `save_addr` and `suppress` keep their values on every cycle that has no match strobe.
- R8: A strobe that arrives in the same cycle as a match does not release that match. A new match always replaces a break that is still waiting.
- R9: `take` is a single-cycle pulse. It is high only in the cycle after a mode-0 match or after the releasing strobe of a mode-1 match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| match_vld | input | 1 | Breakpoint match strobe |
| mode_after | input | 1 | 0: break before execution, 1: break after execution |
| is_dbr | input | 1 | Matched instruction is a delayed branch |
| is_slot | input | 1 | Matched instruction sits in a delay slot |
| insn_addr | input | 32 | Address of the matched instruction |
| next_addr | input | 32 | Next sequential instruction address |
| tgt_addr | input | 32 | Branch destination address |
| owner_addr | input | 32 | Address of the delayed branch owning the slot |
| boundary | input | 1 | Next instruction boundary reached |
| tgt_fetch | input | 1 | First instruction at the branch target is being fetched |
| save_addr | output | 32 | Address to be saved as the return point |
| suppress | output | 1 | Matched instruction must not execute |
| take | output | 1 | Break is taken now (one-cycle pulse) |

## Verification
The main selection is driven with every combination of the two modes and three instruction kinds: plain, delayed branch and delay slot. Each combination uses distinct values on all four address inputs, so a wrong source mux shows up as a wrong value. Odd source addresses separate correct alignment from a raw copy. For the deferred cases, the wrong release strobe is pulsed before the right one. This distinguishes a wait on the branch target from a wait on a plain boundary. Strobes that coincide with a match, a match that overrides a waiting break, and a reset during a wait show whether the pending state is handled correctly.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_BND  = 2'd1,
    W_TGT  = 2'd2
  } wait_e;
endpackage

// File: rtl/brk_addr_pick.sv
module brk_addr_pick
  import brk_pkg::*;
#(
  parameter int AW    = 32,
  parameter int ALIGN = 1
) (
  input  logic          mode_after,
  input  logic          is_dbr,
  input  logic          is_slot,
  input  logic [AW-1:0] insn_addr,
  input  logic [AW-1:0] next_addr,
  input  logic [AW-1:0] tgt_addr,
  input  logic [AW-1:0] owner_addr,
  output logic [AW-1:0] sel_addr,
  output logic          sel_sup,
  output wait_e         sel_wait
);
  logic [AW-1:0] raw;
  logic          branchy;

  assign branchy = is_dbr | is_slot;

  always_comb begin
    if (!mode_after) begin
      raw      = is_slot ? owner_addr : insn_addr;
      sel_sup  = 1'b1;
      sel_wait = W_IDLE;
    end else begin
      raw      = branchy ? tgt_addr : next_addr;
      sel_sup  = 1'b0;
      sel_wait = branchy ? W_TGT : W_BND;
    end
  end

  generate
    if (ALIGN > 0) begin : g_align
      assign sel_addr = {raw[AW-1:ALIGN], {ALIGN{1'b0}}};
    end else begin : g_raw
      assign sel_addr = raw;
    end
  endgenerate
endmodule

// File: rtl/brk_wait_ctl.sv
module brk_wait_ctl
  import brk_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  wait_e load_wait,
  input  logic  boundary,
  input  logic  tgt_fetch,
  output logic  take
);
  wait_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= W_IDLE;
      take  <= 1'b0;
    end else begin
      take <= 1'b0;
      if (load) begin
        state <= load_wait;
        take  <= (load_wait == W_IDLE);
      end else begin
        case (state)
          W_BND: if (boundary) begin
            state <= W_IDLE;
            take  <= 1'b1;
          end
          W_TGT: if (tgt_fetch) begin
            state <= W_IDLE;
            take  <= 1'b1;
          end
          default: state <= W_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/brk_ret_sel.sv
module brk_ret_sel
  import brk_pkg::*;
#(
  parameter int AW    = 32,
  parameter int ALIGN = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          match_vld,
  input  logic          mode_after,
  input  logic          is_dbr,
  input  logic          is_slot,
  input  logic [AW-1:0] insn_addr,
  input  logic [AW-1:0] next_addr,
  input  logic [AW-1:0] tgt_addr,
  input  logic [AW-1:0] owner_addr,
  input  logic          boundary,
  input  logic          tgt_fetch,
  output logic [AW-1:0] save_addr,
  output logic          suppress,
  output logic          take
);
  logic [AW-1:0] sel_addr;
  logic          sel_sup;
  wait_e         sel_wait;

  brk_addr_pick #(.AW(AW), .ALIGN(ALIGN)) u_pick (
    .mode_after (mode_after),
    .is_dbr     (is_dbr),
    .is_slot    (is_slot),
    .insn_addr  (insn_addr),
    .next_addr  (next_addr),
    .tgt_addr   (tgt_addr),
    .owner_addr (owner_addr),
    .sel_addr   (sel_addr),
    .sel_sup    (sel_sup),
    .sel_wait   (sel_wait)
  );

  brk_wait_ctl u_wait (
    .clk       (clk),
    .rst       (rst),
    .load      (match_vld),
    .load_wait (sel_wait),
    .boundary  (boundary),
    .tgt_fetch (tgt_fetch),
    .take      (take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      save_addr <= '0;
      suppress  <= 1'b0;
    end else if (match_vld) begin
      save_addr <= sel_addr;
      suppress  <= sel_sup;
    end
  end
endmodule

// File: rtl/brk_ret_sel_chk.sv
module brk_ret_sel_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          match_vld,
  input logic          mode_after,
  input logic [AW-1:0] save_addr,
  input logic          suppress,
  input logic          take
);
  p_before_take_r2: assert property (@(posedge clk) disable iff (rst)
    match_vld && !mode_after |=> take && suppress);

  p_after_nosup_r4: assert property (@(posedge clk) disable iff (rst)
    match_vld && mode_after |=> !suppress);

  p_align_r6: assert property (@(posedge clk) disable iff (rst)
    !save_addr[0]);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !match_vld |=> $stable(save_addr) && $stable(suppress));

  p_no_same_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    match_vld && mode_after |=> !take);

  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    take && !match_vld |=> !take);
endmodule

bind brk_ret_sel brk_ret_sel_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .match_vld  (match_vld),
  .mode_after (mode_after),
  .save_addr  (save_addr),
  .suppress   (suppress),
  .take       (take)
);

// File: tb/sim_brk_ret_sel.sv
module sim_brk_ret_sel;
  logic        clk = 1'b0;
  logic        rst;
  logic        match_vld, mode_after, is_dbr, is_slot, boundary, tgt_fetch;
  logic [31:0] insn_addr, next_addr, tgt_addr, owner_addr;
  logic [31:0] save_addr;
  logic        suppress, take;

  int total = 0;
  int bad   = 0;
  logic fin = 1'b0;

  always #2 clk = ~clk;

  brk_ret_sel u0 (
    .clk(clk), .rst(rst), .match_vld(match_vld), .mode_after(mode_after),
    .is_dbr(is_dbr), .is_slot(is_slot), .insn_addr(insn_addr),
    .next_addr(next_addr), .tgt_addr(tgt_addr), .owner_addr(owner_addr),
    .boundary(boundary), .tgt_fetch(tgt_fetch), .save_addr(save_addr),
    .suppress(suppress), .take(take)
  );

  typedef struct packed {
    logic        aft;
    logic        dbr;
    logic        slot;
    logic [31:0] ia;
    logic [31:0] na;
    logic [31:0] ta;
    logic [31:0] oa;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b0, 32'h1000, 32'h1002, 32'h2000, 32'h0FFE, 32'h1000},
    '{1'b0, 1'b1, 1'b0, 32'h1100, 32'h1102, 32'h2100, 32'h10FE, 32'h1100},
    '{1'b0, 1'b0, 1'b1, 32'h1202, 32'h1204, 32'h2200, 32'h1200, 32'h1200},
    '{1'b1, 1'b0, 1'b0, 32'h1300, 32'h1302, 32'h2300, 32'h12FE, 32'h1302},
    '{1'b1, 1'b1, 1'b0, 32'h1400, 32'h1402, 32'h4000, 32'h13FE, 32'h4000},
    '{1'b1, 1'b0, 1'b1, 32'h1502, 32'h1504, 32'h4100, 32'h1500, 32'h4100},
    '{1'b0, 1'b0, 1'b0, 32'h1601, 32'h1603, 32'h2600, 32'h15FF, 32'h1600},
    '{1'b1, 1'b0, 1'b0, 32'h1701, 32'h1703, 32'h2700, 32'h16FF, 32'h1702}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    match_vld = 0; mode_after = 0; is_dbr = 0; is_slot = 0;
    boundary = 0; tgt_fetch = 0;
    insn_addr = 32'h0; next_addr = 32'h0; tgt_addr = 32'h0; owner_addr = 32'h0;
  endtask

  task automatic drive(input vec_t v);
    match_vld = 1; mode_after = v.aft; is_dbr = v.dbr; is_slot = v.slot;
    insn_addr = v.ia; next_addr = v.na; tgt_addr = v.ta; owner_addr = v.oa;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle_in();
    rst = 1;
    repeat (3) tick();
    chk("R1 reset save_addr", save_addr, 32'h0);
    chk("R1 reset suppress", {31'b0, suppress}, 32'h0);
    chk("R1 reset take", {31'b0, take}, 32'h0);
    rst = 0;
    tick();

    // table walk: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      logic [31:0] held;
      drive(VEC[i]);
      tick();
      idle_in();
      chk("R2/R3/R4/R5/R6 save_addr", save_addr, VEC[i].exp);
      chk("R2/R4 suppress", {31'b0, suppress}, {31'b0, ~VEC[i].aft});
      held = save_addr;
      if (!VEC[i].aft) begin
        chk("R2 take now", {31'b0, take}, 32'h1);
      end else begin
        chk("R8 no take in match cycle", {31'b0, take}, 32'h0);
        tick();
        chk("R5 waiting no take", {31'b0, take}, 32'h0);
        if (VEC[i].dbr || VEC[i].slot) begin
          boundary = 1; tick(); boundary = 0;
          chk("R5 boundary ignored", {31'b0, take}, 32'h0);
          tick();
          chk("R5 still waiting", {31'b0, take}, 32'h0);
          tgt_fetch = 1; tick(); tgt_fetch = 0;
          chk("R5 take on target", {31'b0, take}, 32'h1);
        end else begin
          boundary = 1; tick(); boundary = 0;
          chk("R4 take on boundary", {31'b0, take}, 32'h1);
        end
      end
      tick();
      chk("R9 pulse ends", {31'b0, take}, 32'h0);
      chk("R7 held", save_addr, held);
    end

    // R8: strobe in the match cycle is not counted
    drive(VEC[4]); tgt_fetch = 1;
    tick(); idle_in();
    chk("R8 same-cycle strobe", {31'b0, take}, 32'h0);
    tick();
    chk("R8 still pending", {31'b0, take}, 32'h0);
    // R8: new before-mode match replaces pending wait
    drive(VEC[0]); tick(); idle_in();
    chk("R8 override addr", save_addr, 32'h1000);
    chk("R8 override take", {31'b0, take}, 32'h1);
    tgt_fetch = 1; tick(); tgt_fetch = 0;
    chk("R8 old wait cleared", {31'b0, take}, 32'h0);

    // R8: boundary wait replaced by target wait
    drive(VEC[3]); tick(); idle_in();
    drive(VEC[5]); tick(); idle_in();
    chk("R8 replaced addr", save_addr, 32'h4100);
    boundary = 1; tick(); boundary = 0;
    chk("R8 old boundary wait gone", {31'b0, take}, 32'h0);
    tgt_fetch = 1; tick(); tgt_fetch = 0;
    chk("R8 new wait released", {31'b0, take}, 32'h1);

    // R1: reset during a wait
    drive(VEC[4]); tick(); idle_in();
    rst = 1; tick();
    chk("R1 reset addr", save_addr, 32'h0);
    rst = 0;
    tgt_fetch = 1; tick(); tgt_fetch = 0;
    chk("R1 wait cleared", {31'b0, take}, 32'h0);
    chk("R1 suppress cleared", {31'b0, suppress}, 32'h0);

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule